// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit counter with four uses, chosen through one control byte. It can run as an interval timer or an event counter: the count climbs to a programmed compare value, falls back to zero and emits an interrupt pulse. In pulse-width mode it measures how long an external input stays high. In frequency mode it counts external edges inside a window of programmable length that the block generates itself. A free-running prescaler supplies the internal time base. The external pin passes through a synchronizer and an edge detector before it is used.

Software reaches the block through simple byte writes and combinational byte reads at a 3-bit address. The compare register is written as two bytes. While the two halves are being written, the compare logic is held off, so a half-written value can never raise a match. A read of the compare address returns the live count, not the stored compare value. The result of each measurement is latched into a separate capture register, which software can read at any time.

Top module: `mmtc_top`

## Requirements
- R1: After reset the count is 0, the overflow flag, the interrupt pulse and the gate output are low, and the control byte (address 2) reads 0x80.
- R2: Control bits [1:0] are the run field. 2'b10 runs the counter. Every other value stops it, and while it is stopped the count and the overflow flag are held at 0.
- R3: Control bit 7 is a self-restoring clear. Writing it as 0 clears the count and the overflow flag on the next clock edge. The bit reads 0 until that edge and reads 1 again afterwards.
- R4: Control bits [6:4] pick the count source. Values 0 to 6 give an internal tick once every 2^n clock cycles. Value 7 gives the synchronized rising edges of `ext_in`.
- R5: In timer/event mode (control bits [3:2] = 2'b00), the count steps through 0 up to compare−1 on each source tick. The step that would reach the compare value returns the count to 0 and raises `irq_o` for one cycle, so an interrupt comes every `compare` ticks. The compare value must be at least 1.
- R6: The compare register takes its low byte at address 0 and its high byte at address 1. A low-byte write suspends matching, and matching stays suspended until the high byte is written. Matching resumes one clock cycle after the high-byte write.
- R7: Reads at addresses 0 and 1 return the low and high bytes of the live count.
- R8: When the count wraps from 0xFFFF to 0, `ovf_o` is set. It stays set until the counter is stopped or cleared.
- R9: In pulse-width mode (2'b10), the count advances on source ticks while the synchronized input is high. On its falling edge, the count is copied to the capture register (low byte at address 4, high byte at address 5), the count returns to 0 and `irq_o` pulses.
- R10: In frequency mode (2'b11), address 3 holds Ta in bits [7:4] and Tb in bits [3:0]. The gate is high for (16−Ta)·2^GATE_SHIFT cycles and low for (16−Tb)·2^GATE_SHIFT cycles, starting high when the counter starts. Source ticks are counted only while the gate is high. When the gate falls, the count is captured, the count returns to 0 and `irq_o` pulses.
- R11: `ext_in` passes through a two-flop synchronizer. Each low-to-high transition, once synchronized, counts as exactly one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 3 | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data at `addr` |
| ext_in | input | 1 | Asynchronous external input |
| irq_o | output | 1 | One-cycle match or capture pulse |
| ovf_o | output | 1 | Sticky overflow flag |
| gate_o | output | 1 | Frequency-mode window gate |

## Verification
The bench builds the block with PRE_W = 8 and GATE_SHIFT = 0. With GATE_SHIFT = 0, a window lasts only 16 high cycles and 2 low cycles, so several complete windows, each with an exact edge count and an exact gate duty, fit into a few hundred cycles. With the 8-bit prescaler, taps of 1, 2 and 4 cycles can be checked against exact interrupt periods. The 16-bit wrap needed for overflow is reached in about 65,600 cycles, because compare matching is left suspended after a lone low-byte write.

// File: rtl/mmtc_pkg.sv
package mmtc_pkg;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_GATE   = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd5;

    localparam logic [2:0] SRC_EXT = 3'd7;

    typedef enum logic [1:0] {
        M_TIMER = 2'b00,
        M_RSVD  = 2'b01,
        M_PULSE = 2'b10,
        M_FREQ  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        RUN_STOP = 2'b00,
        RUN_X1   = 2'b01,
        RUN_GO   = 2'b10,
        RUN_X3   = 2'b11
    } run_e;

    typedef struct packed {
        logic       clr;
        logic [2:0] src;
        mode_e      mode;
        run_e       run;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{clr: 1'b1, src: 3'd0, mode: M_TIMER, run: RUN_STOP};

    // Per-mode condition that lets a source tick advance the count
    function automatic logic mode_qual(input mode_e m, input logic level, input logic gate);
        case (m)
            M_TIMER: mode_qual = 1'b1;
            M_PULSE: mode_qual = level;
            M_FREQ:  mode_qual = gate;
            default: mode_qual = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mmtc_prescaler.sv
module mmtc_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        mask = ~({PRE_W{1'b1}} << sel);
        tick = ((pre_q & mask) == mask);
    end
endmodule

// File: rtl/mmtc_sync.sv
module mmtc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/mmtc_gate.sv
module mmtc_gate #(
    parameter int GATE_SHIFT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [3:0] ta,
    input  logic [3:0] tb,
    output logic       gate,
    output logic       gate_end
);
    localparam int GW = 5 + GATE_SHIFT;

    logic [GW-1:0] cnt_q;
    logic [GW-1:0] hi_len;
    logic [GW-1:0] lo_len;
    logic          phase_hi_q;

    always_comb begin
        hi_len = GW'(5'd16 - {1'b0, ta}) << GATE_SHIFT;
        lo_len = GW'(5'd16 - {1'b0, tb}) << GATE_SHIFT;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q      <= '0;
            phase_hi_q <= 1'b1;
        end else if (phase_hi_q) begin
            if (cnt_q == hi_len - 1'b1) begin
                cnt_q      <= '0;
                phase_hi_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            if (cnt_q == lo_len - 1'b1) begin
                cnt_q      <= '0;
                phase_hi_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign gate     = en & phase_hi_q;
    assign gate_end = gate & (cnt_q == hi_len - 1'b1);
endmodule

// File: rtl/mmtc_top.sv
module mmtc_top
    import mmtc_pkg::*;
#(
    parameter int PRE_W      = 8,
    parameter int GATE_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              ext_in,
    output logic              irq_o,
    output logic              ovf_o,
    output logic              gate_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cmp_q, count_q, cap_q;
    logic [7:0]       stage_lo_q, gate_cfg_q;
    logic             hold_q, resume_q, ovf_q, irq_q;

    logic             pre_tick, ext_level, ext_rise, ext_fall;
    logic             gate, gate_end, running, src_tick, inc;
    logic             match_evt, capture_evt;
    logic [CNT_W:0]   cnt_plus;

    mmtc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .sel(ctrl_q.src), .tick(pre_tick)
    );

    mmtc_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(ext_in),
        .level(ext_level), .rise(ext_rise), .fall(ext_fall)
    );

    mmtc_gate #(.GATE_SHIFT(GATE_SHIFT)) u_gate (
        .clk(clk), .rst(rst),
        .en(running && ctrl_q.mode == M_FREQ && ctrl_q.clr),
        .ta(gate_cfg_q[7:4]), .tb(gate_cfg_q[3:0]),
        .gate(gate), .gate_end(gate_end)
    );

    always_comb begin
        running     = (ctrl_q.run == RUN_GO);
        src_tick    = (ctrl_q.src == SRC_EXT) ? ext_rise : pre_tick;
        inc         = running & src_tick & mode_qual(ctrl_q.mode, ext_level, gate);
        cnt_plus    = {1'b0, count_q} + (CNT_W+1)'(1);
        match_evt   = running && ctrl_q.mode == M_TIMER && inc && !hold_q
                      && cnt_plus == {1'b0, cmp_q};
        capture_evt = running && ((ctrl_q.mode == M_PULSE && ext_fall) ||
                                  (ctrl_q.mode == M_FREQ && gate_end));
    end

    // Register writes and the self-restoring clear bit
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= CTRL_RST;
            cmp_q      <= '0;
            stage_lo_q <= '0;
            gate_cfg_q <= '0;
            hold_q     <= 1'b0;
            resume_q   <= 1'b0;
        end else begin
            if (wr_en && addr == A_CTRL)  ctrl_q <= ctrl_t'(wdata);
            else if (!ctrl_q.clr)         ctrl_q.clr <= 1'b1;

            if (wr_en && addr == A_GATE)  gate_cfg_q <= wdata;

            if (wr_en && addr == A_CMP_LO) begin
                stage_lo_q <= wdata;
                hold_q     <= 1'b1;
            end else if (wr_en && addr == A_CMP_HI) begin
                cmp_q    <= {wdata, stage_lo_q};
                hold_q   <= 1'b1;
                resume_q <= 1'b1;
            end else if (resume_q) begin
                hold_q   <= 1'b0;
                resume_q <= 1'b0;
            end
        end
    end

    // Counting, matching, capture and overflow
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            cap_q   <= '0;
            ovf_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (!running || !ctrl_q.clr) begin
                count_q <= '0;
                ovf_q   <= 1'b0;
            end else if (capture_evt) begin
                cap_q   <= count_q + CNT_W'(inc);
                count_q <= '0;
                irq_q   <= 1'b1;
            end else if (match_evt) begin
                count_q <= '0;
                irq_q   <= 1'b1;
            end else if (inc) begin
                count_q <= cnt_plus[CNT_W-1:0];
                if (cnt_plus[CNT_W]) ovf_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (addr)
            A_CMP_LO: rdata = count_q[7:0];
            A_CMP_HI: rdata = count_q[15:8];
            A_CTRL:   rdata = ctrl_q;
            A_GATE:   rdata = gate_cfg_q;
            A_CAP_LO: rdata = cap_q[7:0];
            A_CAP_HI: rdata = cap_q[15:8];
            default:  rdata = 8'h00;
        endcase
    end

    assign irq_o  = irq_q;
    assign ovf_o  = ovf_q;
    assign gate_o = gate;
endmodule

// File: rtl/mmtc_checker.sv
module mmtc_checker
    import mmtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input ctrl_t             ctrl_q,
    input logic [CNT_W-1:0]  count_q,
    input logic              hold_q,
    input logic              irq_o,
    input logic              ovf_o
);
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run != RUN_GO) |=> (count_q == '0 && !ovf_o)); // R2

    AST_CLEAR_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.clr && !(wr_en && addr == A_CTRL)) |=> ctrl_q.clr); // R3

    AST_MATCH_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (irq_o && ctrl_q.mode == M_TIMER) |-> (count_q == '0)); // R5

    AST_HOLD_SILENCES: assert property (@(posedge clk) disable iff (rst)
        (hold_q && ctrl_q.mode == M_TIMER) |=> !irq_o); // R6

    AST_HI_WRITE_GAP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CMP_HI && ctrl_q.mode == M_TIMER) |=> ##1 !irq_o); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && ctrl_q.run == RUN_GO && ctrl_q.clr) |=> ovf_o); // R8
endmodule

bind mmtc_top mmtc_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .ctrl_q(ctrl_q),
    .count_q(count_q), .hold_q(hold_q), .irq_o(irq_o), .ovf_o(ovf_o)
);

// File: tb/mmtc_top_tb.sv
`timescale 1ns/1ps
module mmtc_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ext_in = 1'b0;
    logic       irq_o, ovf_o, gate_o;

    int total = 0;
    int bad = 0;
    int irq_seen = 0;
    int gate_seen = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    mmtc_top #(.PRE_W(8), .GATE_SHIFT(0)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_in(ext_in), .irq_o(irq_o), .ovf_o(ovf_o), .gate_o(gate_o)
    );

    always @(posedge clk) begin
        #2;
        if (irq_o)  irq_seen++;
        if (gate_o) gate_seen++;
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        int v;
        rd(3'd2, v);
        check("R1 control reset value", v, 8'h80);
        rd(3'd0, v);
        check("R1 count low after reset", v, 0);
        check("R1 overflow after reset", ovf_o, 0);
        check("R1 irq after reset", irq_o, 0);
        check("R1 gate after reset", gate_o, 0);
    endtask

    task automatic t_timer();
        int b;
        wr(3'd2, 8'h80);
        wr(3'd0, 8'd5);
        wr(3'd1, 8'd0);
        wr(3'd2, 8'h82);
        step(3);
        b = irq_seen;
        step(50);
        check("R5 interrupts in 50 cycles, compare 5", irq_seen - b, 10);
        wr(3'd2, 8'h80);
        step(1);
        rd(3'd0, b);
        check("R2 count cleared while stopped", b, 0);
    endtask

    task automatic t_prescale();
        int b;
        wr(3'd0, 8'd3);
        wr(3'd1, 8'd0);
        wr(3'd2, 8'hA2);
        step(20);
        b = irq_seen;
        step(120);
        check("R4 tap 2 with compare 3 gives 10 interrupts in 120 cycles", irq_seen - b, 10);
        wr(3'd2, 8'h80);
    endtask

    task automatic t_live();
        int v;
        wr(3'd0, 8'hE8);
        wr(3'd1, 8'h03);
        wr(3'd2, 8'h82);
        step(20);
        rd(3'd0, v);
        check("R7 low read returns live count", v, 20);
        rd(3'd1, v);
        check("R7 high read returns live count", v, 0);
        wr(3'd2, 8'h80);
    endtask

    task automatic t_hold_ovf();
        int b, v;
        wr(3'd0, 8'd3);
        wr(3'd1, 8'd0);
        wr(3'd2, 8'h82);
        wr(3'd0, 8'd3);
        step(2);
        b = irq_seen;
        step(20);
        check("R6 no match after lone low-byte write", irq_seen - b, 0);
        step(65600);
        check("R8 overflow set after wrap", ovf_o, 1);
        wr(3'd1, 8'd0);
        wr(3'd2, 8'h02);
        rd(3'd2, v);
        check("R3 clear bit reads 0 before clearing", v, 8'h02);
        step(1);
        check("R3 overflow cleared by clear bit", ovf_o, 0);
        rd(3'd2, v);
        check("R3 clear bit restored", v, 8'h82);
        step(3);
        b = irq_seen;
        step(30);
        check("R6 matching resumes after high byte", irq_seen - b, 10);
        wr(3'd2, 8'h80);
    endtask

    task automatic t_event();
        int b, v;
        ext_in = 1'b0;
        wr(3'd0, 8'd4);
        wr(3'd1, 8'd0);
        wr(3'd2, 8'hF2);
        b = irq_seen;
        for (int i = 0; i < 9; i++) begin
            ext_in = 1'b1; step(3);
            ext_in = 1'b0; step(3);
        end
        step(4);
        check("R11 two matches from nine edges, compare 4", irq_seen - b, 2);
        rd(3'd0, v);
        check("R11 event count remainder", v, 1);
        wr(3'd2, 8'h80);
    endtask

    task automatic t_pulse(input logic [7:0] stop_c, input logic [7:0] go_c, input int exp);
        int b, v;
        wr(3'd2, stop_c);
        wr(3'd2, go_c);
        step(2);
        b = irq_seen;
        ext_in = 1'b1;
        step(20);
        ext_in = 1'b0;
        step(5);
        rd(3'd4, v);
        check("R9 captured pulse width", v, exp);
        rd(3'd5, v);
        check("R9 capture high byte", v, 0);
        check("R9 one interrupt per pulse", irq_seen - b, 1);
        rd(3'd0, v);
        check("R9 count back at 0 after capture", v, 0);
    endtask

    task automatic t_freq();
        int v = -1;
        int gb = 0, ib = 0, ge = 0, ie = 0;
        wr(3'd3, 8'h0E);
        wr(3'd2, 8'hFC);
        wr(3'd2, 8'hFE);
        addr = 3'd4;
        for (int i = 0; i < 60; i++) begin
            if (i == 20) begin gb = gate_seen; ib = irq_seen; end
            if (i == 38) begin ge = gate_seen; ie = irq_seen; end
            if (i == 45) begin #1; v = rdata; end
            ext_in = 1'b1; step(2);
            ext_in = 1'b0; step(2);
        end
        check("R10 edges captured in one window", v, 4);
        check("R10 gate high cycles over 4 windows", ge - gb, 64);
        check("R10 one capture interrupt per window", ie - ib, 4);
        wr(3'd2, 8'hFC);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_timer();
        t_prescale();
        t_live();
        t_hold_ovf();
        t_event();
        t_pulse(8'h88, 8'h8A, 20);
        t_pulse(8'h98, 8'h9A, 10);
        t_freq();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule